// File: doc/BRIEF.md
# Option Byte Programming Engine

This block owns a small non-volatile-style option area of eight entries and the sequencer that changes it. Each entry is a half-word that holds a configuration byte in its low half and that byte's bitwise inverse in its high half. A blank entry reads as all ones. The entries are assigned as follows: index 0 is the read-protect level, index 1 is the hardware configuration, indices 2 and 3 are user data, and indices 4 to 7 are write-protect masks.

Software supplies only the byte. The engine produces the inverse half itself. Before any write, it reads the target entry and refuses to write over a location that is not blank. A separate command wipes the whole area back to blank.

Lowering the read-protect level needs extra care. Any value other than the designated unprotected code counts as protected, and that includes the blank value. When a write would move the level from protected to unprotected, the engine first asks the main-array controller for a full mass erase. It waits for that erase to be acknowledged, and only then commits the new level.

Permission to change options arrives as a single enable input. The unlock logic lives elsewhere.

Top module: `opt_engine`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, perr_o and mer_req_o are all 0.
- R2: A byte write (wr_valid_i) is accepted only when opt_wen_i and prog_en_i are both 1 and the engine is idle. An erase start (start_i) is accepted only when opt_wen_i and erase_en_i are both 1 and the engine is idle. Any other request leaves busy_o at 0 and the stored contents unchanged.
- R3: An accepted write to a blank entry stores {~b, b}, where b is wr_byte_i, so bits 15:8 hold the inverse of bits 7:0.
- R4: If the target entry does not read 16'hFFFF, the write is skipped. In that case perr_o is set, the entry keeps its value and done_o stays 0.
- R5: A write that needs no mass erase holds busy_o high for exactly 3 cycles. A skipped write holds it for 2 cycles. done_o rises in the same cycle that busy_o falls and stays set.
- R6: An accepted erase writes 16'hFFFF into all N_ENTRIES entries and holds busy_o high for exactly N_ENTRIES cycles, then sets done_o.
- R7: Writing the unprotected code (default 8'hA5) into the blank read-protect entry (index RDP_IDX, default 0) raises mer_req_o. mer_req_o is held until mer_done_i, and the entry stays blank until then. Any other byte, or any other index, never raises mer_req_o.
- R8: rd_data_o presents the entry at rd_addr_i one cycle later. cmp_err_o is 1 only when that half-word is not 16'hFFFF and its high byte is not the inverse of its low byte.
- R9: stat_clr_i clears done_o and perr_o on the next clock edge.
- R10: Write or erase requests that arrive while busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_wen_i | input | 1 | Option change permission |
| prog_en_i | input | 1 | Byte program mode select |
| erase_en_i | input | 1 | Area erase mode select |
| start_i | input | 1 | Erase start pulse |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_addr_i | input | AW | Target entry index |
| wr_byte_i | input | BW | Byte to program |
| stat_clr_i | input | 1 | Clear done and error flags |
| mer_done_i | input | 1 | Mass erase completed acknowledge |
| rd_addr_i | input | AW | Read port index |
| rd_data_o | output | 2*BW | Stored half-word, one cycle latency |
| cmp_err_o | output | 1 | Inverse-pair mismatch on read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Sticky end-of-operation flag |
| perr_o | output | 1 | Sticky skipped-write flag |
| mer_req_o | output | 1 | Mass erase request to main array |

## Verification
The bench builds the engine with its defaults: eight byte-wide entries, the read-protect level at index 0 and an unprotected code of 8'hA5. With eight entries, the exact length of the erase sweep can be counted and every entry can be read back after each operation. Because the read-protect slot is at index 0 and the code is a fixed byte, random traffic regularly hits the mass-erase path, which lets the bench check the held request and the deferred write under changing hold times.

// File: rtl/opt_engine_pkg.sv
package opt_engine_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDCHK,
    ST_DECIDE,
    ST_MERW,
    ST_WRITE,
    ST_ERASE
  } seq_st_e;
endpackage

// File: rtl/opt_store.sv
module opt_store #(
  parameter int N  = 8,
  parameter int BW = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int HW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [HW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [HW-1:0] rdata_a,
  output logic [HW-1:0] rdata_b
);
  logic [HW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

  // Every non-blank word reaching the array must be a valid inverse pair.
  assert_cmp_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata != '1)) |-> (wdata[HW-1:BW] == ~wdata[BW-1:0]));
endmodule

// File: rtl/opt_seq.sv
module opt_seq
  import opt_engine_pkg::*;
#(
  parameter int          N       = 8,
  parameter int          BW      = 8,
  parameter int          RDP_IDX = 0,
  parameter logic [BW-1:0] UNPROT = 8'hA5,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int HW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opt_wen,
  input  logic          prog_en,
  input  logic          erase_en,
  input  logic          start,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_byte,
  input  logic          stat_clr,
  input  logic          mer_done,
  input  logic [HW-1:0] chk_data,
  output logic [AW-1:0] chk_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [HW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic          perr,
  output logic          mer_req
);
  seq_st_e       st;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] cnt;
  logic [BW-1:0] byte_q;
  logic          lowers;

  assign lowers = (addr_q == AW'(RDP_IDX)) && (chk_data[BW-1:0] != UNPROT)
                  && (byte_q == UNPROT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      perr    <= 1'b0;
      mer_req <= 1'b0;
    end else begin
      if (stat_clr) begin
        done <= 1'b0;
        perr <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (opt_wen && prog_en && wr_valid) begin
            addr_q <= wr_addr;
            byte_q <= wr_byte;
            busy   <= 1'b1;
            st     <= ST_RDCHK;
          end else if (opt_wen && erase_en && start) begin
            cnt  <= '0;
            busy <= 1'b1;
            st   <= ST_ERASE;
          end
        end
        ST_RDCHK: st <= ST_DECIDE;
        ST_DECIDE: begin
          if (chk_data != '1) begin
            perr <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else if (lowers) begin
            mer_req <= 1'b1;
            st      <= ST_MERW;
          end else begin
            st <= ST_WRITE;
          end
        end
        ST_MERW: begin
          if (mer_done) begin
            mer_req <= 1'b0;
            st      <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        ST_ERASE: begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(N - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    chk_addr = addr_q;
    we       = (st == ST_WRITE) || (st == ST_ERASE);
    waddr    = (st == ST_ERASE) ? cnt : addr_q;
    wdata    = (st == ST_ERASE) ? '1 : {~byte_q, byte_q};
  end

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
  assert_mer_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mer_req |-> busy);
  assert_mer_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mer_req && !mer_done) |=> mer_req);
  assert_no_write_in_mer_R7: assert property (@(posedge clk) disable iff (rst)
    mer_req |-> !we);
endmodule

// File: rtl/opt_engine.sv
module opt_engine #(
  parameter int          N_ENTRIES = 8,
  parameter int          BW        = 8,
  parameter int          RDP_IDX   = 0,
  parameter logic [BW-1:0] UNPROT  = 8'hA5,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int HW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opt_wen_i,
  input  logic          prog_en_i,
  input  logic          erase_en_i,
  input  logic          start_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [BW-1:0] wr_byte_i,
  input  logic          stat_clr_i,
  input  logic          mer_done_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [HW-1:0] rd_data_o,
  output logic          cmp_err_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          perr_o,
  output logic          mer_req_o
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] chk_addr;
  logic [HW-1:0] wdata;
  logic [HW-1:0] chk_data;

  opt_seq #(.N(N_ENTRIES), .BW(BW), .RDP_IDX(RDP_IDX), .UNPROT(UNPROT)) u_seq (
    .clk(clk), .rst(rst), .opt_wen(opt_wen_i), .prog_en(prog_en_i),
    .erase_en(erase_en_i), .start(start_i), .wr_valid(wr_valid_i),
    .wr_addr(wr_addr_i), .wr_byte(wr_byte_i), .stat_clr(stat_clr_i),
    .mer_done(mer_done_i), .chk_data(chk_data), .chk_addr(chk_addr),
    .we(we), .waddr(waddr), .wdata(wdata), .busy(busy_o), .done(done_o),
    .perr(perr_o), .mer_req(mer_req_o)
  );

  opt_store #(.N(N_ENTRIES), .BW(BW)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(chk_addr), .raddr_b(rd_addr_i),
    .rdata_a(chk_data), .rdata_b(rd_data_o)
  );

  assign cmp_err_o = (rd_data_o != '1) && (rd_data_o[HW-1:BW] != ~rd_data_o[BW-1:0]);

  assert_locked_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && wr_valid_i && !opt_wen_i && !start_i) |=> !busy_o);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && !done_o && !perr_o && !mer_req_o));
endmodule

// File: tb/tb_opt_engine.sv
module tb_opt_engine;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opt_wen = 1'b0, prog_en = 1'b0, erase_en = 1'b0, start = 1'b0;
  logic        wr_valid = 1'b0, stat_clr = 1'b0, mer_done = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic [15:0] rd_data;
  logic        cmp_err, busy, done, perr, mer_req;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_mem [N];

  always #2 clk = ~clk;

  opt_engine dut (
    .clk(clk), .rst(rst), .opt_wen_i(opt_wen), .prog_en_i(prog_en),
    .erase_en_i(erase_en), .start_i(start), .wr_valid_i(wr_valid),
    .wr_addr_i(wr_addr), .wr_byte_i(wr_byte), .stat_clr_i(stat_clr),
    .mer_done_i(mer_done), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cmp_err_o(cmp_err), .busy_o(busy), .done_o(done), .perr_o(perr),
    .mer_req_o(mer_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] pair(input logic [7:0] b);
    return {~b, b};
  endfunction

  task automatic read_all();
    for (int i = 0; i < N; i++) begin
      rd_addr = 3'(i);
      @(negedge clk);
      chk(rd_data == exp_mem[i], "R3 R4 R6 contents", {16'd0, rd_data}, {16'd0, exp_mem[i]});
      chk(cmp_err == 1'b0, "R8 cmp_err", {31'd0, cmp_err}, 32'd0);
    end
  endtask

  task automatic clear_status();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk(!done && !perr, "R9 status clear", {30'd0, done, perr}, 32'd0);
  endtask

  task automatic do_erase(input bit wen, input bit een);
    int cyc;
    bit acc;
    clear_status();
    acc = wen && een;
    opt_wen = wen; erase_en = een; prog_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (acc) begin
      chk(cyc == N, "R6 erase busy length", cyc, N);
      chk(done == 1'b1, "R6 done after erase", {31'd0, done}, 32'd1);
      for (int i = 0; i < N; i++) exp_mem[i] = 16'hFFFF;
    end else begin
      chk(cyc == 0, "R2 erase ignored", cyc, 0);
    end
    erase_en = 1'b0;
    read_all();
  endtask

  task automatic do_prog(input logic [2:0] a, input logic [7:0] b, input bit wen,
                         input bit pen, input bit burst, input int hold_len);
    int cyc, hold;
    bit acc, nonblank, mer_exp, mer_seen;
    clear_status();
    acc      = wen && pen;
    nonblank = (exp_mem[a] != 16'hFFFF);
    mer_exp  = acc && !nonblank && (a == 3'd0) && (b == 8'hA5);
    rd_addr  = 3'd0;
    opt_wen = wen; prog_en = pen; erase_en = 1'b0;
    wr_addr = a; wr_byte = b; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    cyc = 0; hold = 0; mer_seen = 1'b0;
    while (busy && cyc < 200) begin
      if (burst && cyc == 0) begin
        wr_addr = a ^ 3'd1; wr_byte = 8'h3C; wr_valid = 1'b1;
      end
      mer_done = 1'b0;
      if (mer_req) begin
        mer_seen = 1'b1;
        hold++;
        if (hold == hold_len) begin
          // R7: read-protect entry still blank while the erase is pending
          chk(rd_data == 16'hFFFF, "R7 deferred write", {16'd0, rd_data}, 32'h0000FFFF);
          mer_done = 1'b1;
        end
      end
      @(negedge clk);
      cyc++;
      wr_valid = 1'b0;
    end
    mer_done = 1'b0;
    if (!acc) begin
      chk(cyc == 0, "R2 write ignored", cyc, 0);
    end else begin
      if (nonblank) chk(cyc == 2, "R5 skipped busy length", cyc, 2);
      else if (!mer_exp) chk(cyc == 3, "R5 write busy length", cyc, 3);
      chk(perr == nonblank, "R4 perr", {31'd0, perr}, {31'd0, nonblank});
      chk(done == !nonblank, "R5 done", {31'd0, done}, {31'd0, !nonblank});
      chk(mer_seen == mer_exp, "R7 mer request", {31'd0, mer_seen}, {31'd0, mer_exp});
      if (!nonblank) exp_mem[a] = pair(b);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R10 no follow-on op", {31'd0, busy}, 32'd0);
    prog_en = 1'b0;
    read_all();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) exp_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !perr && !mer_req, "R1 reset state",
        {28'd0, busy, done, perr, mer_req}, 32'd0);

    do_erase(1'b1, 1'b1);               // R6 full sweep
    do_prog(3'd3, 8'h34, 1, 1, 0, 1);   // R3 inverse pair
    do_prog(3'd3, 8'h77, 1, 1, 0, 1);   // R4 non-blank target
    do_prog(3'd5, 8'h12, 0, 1, 0, 1);   // R2 no permission
    do_prog(3'd5, 8'h12, 1, 0, 0, 1);   // R2 program mode off
    do_prog(3'd2, 8'hA5, 1, 1, 0, 1);   // R7 code on other index
    do_prog(3'd6, 8'hFF, 1, 1, 1, 1);   // R10 burst while busy, R3 0x00FF
    do_prog(3'd0, 8'hA5, 1, 1, 0, 4);   // R7 lowering protection
    do_erase(1'b0, 1'b1);               // R2 erase without permission
    do_erase(1'b1, 1'b1);
    do_prog(3'd0, 8'h5A, 1, 1, 0, 1);   // R7 other level, no request
    do_erase(1'b1, 1'b1);

    // R9: flag survives until cleared
    opt_wen = 1'b1; prog_en = 1'b1; wr_addr = 3'd4; wr_byte = 8'h81; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9 done held", {31'd0, done}, 32'd1);
    exp_mem[4] = pair(8'h81);
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    chk(done == 1'b0, "R9 done cleared", {31'd0, done}, 32'd0);
    prog_en = 1'b0;

    for (int k = 0; k < 150; k++) begin
      int r;
      logic [2:0] a;
      logic [7:0] b;
      r = int'($urandom % 10);
      a = 3'($urandom % 8);
      b = 8'($urandom);
      if (a == 3'd0 && ($urandom % 2) == 0) b = 8'hA5;
      if (r == 0) do_erase(($urandom % 8) != 0, ($urandom % 8) != 0);
      else do_prog(a, b, ($urandom % 8) != 0, ($urandom % 8) != 0,
                   ($urandom % 4) == 0, 1 + int'($urandom % 6));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule